// File: doc/BRIEF.md
# Stepped Stereo Attenuator with Soft Mute

This block scales a stereo stream of signed 16-bit samples by a linear gain held in a 6-bit level register. The gain equals level/63. Code 63 passes samples through unchanged and code 0 gives silence. Each sample strobe produces one pair of scaled samples on the next clock.

The level register runs in one of two modes, selected by `soft_mode`.

- **Manual mode** (`soft_mode` low): an external step clock moves the level by one code on each of its rising edges. The `mute_dn` input sets the direction.
- **Soft-mute mode** (`soft_mode` high): the step clock is ignored. The level ramps by itself at one code every 16 sample strobes. It moves toward silence while `mute_dn` is high and back toward full gain while it is low.

Reset loads full gain, and so does every change of mode. The mode, direction and step-clock inputs are asynchronous. Each passes through a two-flop synchroniser before the control logic uses it.

The level controller is a three-state machine:

- `LV_RELOAD` forces the level to 63 and clears the strobe divider. It is entered at reset and whenever the synchronised mode differs from its previous value. On the next cycle it leaves for `LV_MANUAL` or `LV_SOFT`, according to the mode.
- `LV_MANUAL` steps on detected step-clock rising edges. It returns to `LV_RELOAD` on a mode change.
- `LV_SOFT` steps on every sixteenth sample strobe. It returns to `LV_RELOAD` on a mode change.

Top module: `gain_ramp_atten`

## Requirements
- R1: The gain is level/63. At level 63 every sample leaves unchanged, including -32768 and 32767. At level 0 every output sample is 0.
- R2: In manual mode the level changes by exactly one code for each rising edge of `step_clk`, and it does not change without one.
- R3: In manual mode, `mute_dn` high makes each step decrement the level and `mute_dn` low makes each step increment it.
- R4: The level saturates: decrement steps at 0 leave it at 0, and increment steps at 63 leave it at 63.
- R5: After reset, and within five clocks after any change of `soft_mode`, the level equals 63.
- R6: In soft-mute mode, rising edges of `step_clk` have no effect on the level.
- R7: In soft-mute mode with `mute_dn` high, the level falls by one code on every sixteenth sample strobe. The strobe count restarts from zero at each reload, so a full ramp from 63 to 0 takes 1008 strobes.
- R8: In soft-mute mode with `mute_dn` low, the level rises by one code on every sixteenth sample strobe, until it reaches 63.
- R9: One clock after a sample strobe, `out_valid` is high for one cycle. `out_left` and `out_right` then equal the input samples times the level, divided by 63 and truncated toward zero, using the level held in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per stereo pair |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| soft_mode | input | 1 | High selects soft-mute mode, low selects manual mode (asynchronous) |
| mute_dn | input | 1 | Direction: high counts down or mutes, low counts up or releases (asynchronous) |
| step_clk | input | 1 | External step clock for manual mode (asynchronous) |
| out_valid | output | 1 | Scaled pair valid |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| level | output | 6 | Current gain code, 0 to 63 |

## Verification
The assertions check on every cycle that the level moves by no more than one code outside a reload. They also check that it holds at 0 and at 63 against the matching direction, that a mode change lands on 63, and that the level stays still in soft mode between strobes and in manual mode between step edges. They also check that levels 63 and 0 give unity and silence at the output.

Only the bench scenarios can show the following:
- the exact strobe count of a soft ramp;
- rounding toward zero for negative samples at intermediate levels;
- the direction chosen by `mute_dn`;
- that the step clock is ignored while soft mode is active.

// File: rtl/atten_pkg.sv
package atten_pkg;
    typedef enum logic [1:0] {
        LV_RELOAD = 2'd0,
        LV_MANUAL = 2'd1,
        LV_SOFT   = 2'd2
    } lvl_state_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/atten_level_ctrl.sv
module atten_level_ctrl
    import atten_pkg::*;
#(
    parameter int LEVEL_W  = 6,
    parameter int TICK_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_s,
    input  logic               mute_s,
    input  logic               step_s,
    input  logic               smp_valid,
    output logic [LEVEL_W-1:0] level
);
    localparam logic [LEVEL_W-1:0] LMAX   = {LEVEL_W{1'b1}};
    localparam int                 TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TICK_W-1:0]  TLAST  = TICK_W'(TICK_DIV - 1);

    lvl_state_e        state, state_nx;
    logic              step_prev, mode_prev;
    logic              step_rise, mode_chg;
    logic [TICK_W-1:0] tick;

    assign step_rise = step_s & ~step_prev;
    assign mode_chg  = mode_s ^ mode_prev;

    // edge and change detection registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_prev <= 1'b0;
            mode_prev <= 1'b0;
        end else begin
            step_prev <= step_s;
            mode_prev <= mode_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LV_RELOAD;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            LV_RELOAD: begin
                if (mode_chg)    state_nx = LV_RELOAD;
                else if (mode_s) state_nx = LV_SOFT;
                else             state_nx = LV_MANUAL;
            end
            LV_MANUAL: if (mode_chg) state_nx = LV_RELOAD;
            LV_SOFT:   if (mode_chg) state_nx = LV_RELOAD;
            default:   state_nx = LV_RELOAD;
        endcase
    end

    // level and strobe divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= LMAX;
            tick  <= '0;
        end else if (mode_chg || state == LV_RELOAD) begin
            level <= LMAX;
            tick  <= '0;
        end else begin
            unique case (state)
                LV_MANUAL: begin
                    if (step_rise) begin
                        if (mute_s && level != '0)        level <= level - 1'b1;
                        else if (!mute_s && level != LMAX) level <= level + 1'b1;
                    end
                end
                LV_SOFT: begin
                    if (smp_valid) begin
                        if (tick == TLAST) begin
                            tick <= '0;
                            if (mute_s && level != '0)        level <= level - 1'b1;
                            else if (!mute_s && level != LMAX) level <= level + 1'b1;
                        end else begin
                            tick <= tick + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LV_RELOAD && !mode_chg) |=>
        (level == $past(level) || level == $past(level) + 1'b1 || level == $past(level) - 1'b1)); // R2
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LV_MANUAL && !mode_chg && !step_rise) |=> $stable(level)); // R2
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LV_RELOAD && !mode_chg && mute_s && level == '0) |=> level == '0); // R4
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LV_RELOAD && !mode_chg && !mute_s && level == LMAX) |=> level == LMAX); // R4
    AST_MODE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> level == LMAX); // R5
    AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LV_SOFT && !mode_chg && !smp_valid) |=> $stable(level)); // R6
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
    parameter int DATA_W  = 16,
    parameter int LEVEL_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_smp,
    input  logic [LEVEL_W-1:0]       level,
    output logic signed [DATA_W-1:0] out_smp
);
    localparam int                 PROD_W  = DATA_W + LEVEL_W + 1;
    localparam int                 LMAX_I  = (1 << LEVEL_W) - 1;
    localparam logic [LEVEL_W-1:0] LMAX    = LEVEL_W'(LMAX_I);
    localparam logic signed [PROD_W-1:0] DIVISOR = PROD_W'(LMAX_I);

    logic signed [PROD_W-1:0] prod, quot;

    always_comb begin
        prod = PROD_W'(in_smp) * $signed({{(PROD_W-LEVEL_W){1'b0}}, level});
        quot = prod / DIVISOR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_smp <= '0;
        else if (in_valid) out_smp <= DATA_W'(quot);
    end

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && level == LMAX) |=> out_smp == $past(in_smp)); // R1
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && level == '0) |=> out_smp == '0); // R1
endmodule

// File: rtl/gain_ramp_atten.sv
module gain_ramp_atten
    import atten_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LEVEL_W     = 6,
    parameter int TICK_DIV    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    input  logic              soft_mode,
    input  logic              mute_dn,
    input  logic              step_clk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic [LEVEL_W-1:0] level
);
    logic [2:0] async_in, synced;
    logic signed [DATA_W-1:0] ch_in  [NUM_CH];
    logic signed [DATA_W-1:0] ch_out [NUM_CH];

    assign async_in = {soft_mode, mute_dn, step_clk};

    atten_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (synced)
    );

    atten_level_ctrl #(.LEVEL_W(LEVEL_W), .TICK_DIV(TICK_DIV)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (synced[2]),
        .mute_s    (synced[1]),
        .step_s    (synced[0]),
        .smp_valid (smp_valid),
        .level     (level)
    );

    assign ch_in[0] = smp_left;
    assign ch_in[1] = smp_right;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        atten_scale #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_scale (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (smp_valid),
            .in_smp   (ch_in[c]),
            .level    (level),
            .out_smp  (ch_out[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= smp_valid;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid); // R9
endmodule

// File: tb/gain_ramp_atten_tb.sv
module gain_ramp_atten_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0, smp_right = '0;
    logic        soft_mode = 1'b0, mute_dn = 1'b0, step_clk = 1'b0;
    logic        out_valid;
    logic [15:0] out_left, out_right;
    logic [5:0]  level;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gain_ramp_atten u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .soft_mode(soft_mode), .mute_dn(mute_dn), .step_clk(step_clk),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .level(level)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            step_clk = 1'b1; settle(3);
            step_clk = 1'b0; settle(3);
        end
        settle(5);
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1; settle(1);
            smp_valid = 1'b0; settle(1);
        end
    endtask

    function automatic int scaled(int x, int lv);
        return (x * lv) / 63;
    endfunction

    task automatic sample_chk(string req, int l, int r);
        int lv;
        lv = level;
        smp_left = 16'(l); smp_right = 16'(r); smp_valid = 1'b1;
        settle(1);
        smp_valid = 1'b0;
        chk({req, " out_valid"}, int'(out_valid), 1);
        chk({req, " left"}, int'($signed(out_left)), scaled(l, lv));
        chk({req, " right"}, int'($signed(out_right)), scaled(r, lv));
        settle(1);
        chk({req, " valid drop"}, int'(out_valid), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; settle(3);
        chk("R5 reset level", int'(level), 63);
        chk("R9 reset valid", int'(out_valid), 0);
        rst_n = 1'b1; settle(4);
        chk("R5 level after reset", int'(level), 63);
    endtask

    task automatic t_unity;
        sample_chk("R1 unity full scale", 32767, -32768);
        sample_chk("R1 unity mixed", -1234, 567);
    endtask

    task automatic t_manual_down;
        mute_dn = 1'b1; settle(4);
        pulses(5);
        chk("R2 R3 down five steps", int'(level), 58);
        sample_chk("R9 level 58", 1000, -1000);
    endtask

    task automatic t_sat_low;
        pulses(70);
        chk("R4 saturate at 0", int'(level), 0);
        sample_chk("R1 silence", 12345, -32768);
    endtask

    task automatic t_manual_up;
        mute_dn = 1'b0; settle(4);
        pulses(10);
        chk("R3 up ten steps", int'(level), 10);
        sample_chk("R9 level 10", -32768, 32767);
        pulses(60);
        chk("R4 saturate at 63", int'(level), 63);
    endtask

    task automatic t_mode_reload;
        mute_dn = 1'b1; settle(4);
        pulses(23);
        chk("R2 down to 40", int'(level), 40);
        soft_mode = 1'b1; settle(6);
        chk("R5 reload on soft entry", int'(level), 63);
    endtask

    task automatic t_soft_ignore;
        pulses(8);
        chk("R6 step clock ignored", int'(level), 63);
    endtask

    task automatic t_soft_down;
        strobes(15);
        chk("R7 no step before 16", int'(level), 63);
        strobes(1);
        chk("R7 step on 16th", int'(level), 62);
        strobes(992);
        chk("R7 full ramp 1008", int'(level), 0);
        strobes(16);
        chk("R4 soft hold at 0", int'(level), 0);
    endtask

    task automatic t_soft_up;
        mute_dn = 1'b0; settle(4);
        strobes(32);
        chk("R8 two steps up", int'(level), 2);
        strobes(976);
        chk("R8 back to 63", int'(level), 63);
    endtask

    task automatic t_back_manual;
        mute_dn = 1'b1; settle(4);
        strobes(160);
        chk("R7 ten steps down", int'(level), 53);
        soft_mode = 1'b0; settle(6);
        chk("R5 reload on manual entry", int'(level), 63);
        pulses(1);
        chk("R2 single step", int'(level), 62);
        sample_chk("R9 level 62 extremes", 32767, -32768);
        sample_chk("R9 toward zero small", 1, -1);
    endtask

    initial begin
        t_reset();
        t_unity();
        t_manual_down();
        t_sat_low();
        t_manual_up();
        t_mode_reload();
        t_soft_ignore();
        t_soft_down();
        t_soft_up();
        t_back_manual();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule